// File: doc/BRIEF.md
# Bit-banged I2C serial EEPROM slave

This block behaves as a 256-byte serial EEPROM on a two-wire bus whose lines are not real pads. A host sets the levels of the data line and the clock line by writing a two-bit word. Each write strobe is one update step. The block compares the new levels with the ones it stored on the previous strobe. From that it finds start and stop conditions and clock edges, and then it moves its protocol state machine on by one step. The level the slave puts on the data line is returned on a readback port. It is valid one clock after the strobe and stays there until the next strobe.

The state machine has six states: idle, device select, word-address capture, write data, read data, and a parked state that waits for a stop. Every bit is sampled on a falling clock edge, and the value taken is the data level that was present just before that edge. The first four bits of the device-select byte are not checked. Writes go into storage one bit at a time, MSB first. After each full write byte, the word address advances inside a page mask; after each full read byte, it advances across the whole array. The storage is a single-bit-wide array, so a block RAM can be inferred for it.

Top module: `eep_i2c_slave`

## Requirements
- R1: While reset is held, and after it is released, the block is idle and host_rdata reads 2'b10: bit 1 is the slave data level and bit 0 is always 0.
- R2: A start condition (data falls while the new clock level is 1) sends the block to device select with its bit counter cleared, from every state except the parked one. A stop condition (data rises while the new clock level is 1) returns the block to idle from any state. In idle, in the parked state, and in every slot where the slave neither acknowledges nor sends data, bit 1 of the readback echoes the data level last written by the host.
- R3: In device select, the counter first needs a rising clock edge. After that, each falling edge takes one bit, MSB first. The first four bits are a type code and are ignored. The next three bits are the device address. The eighth bit is the direction, and 1 means read.
- R4: The slave drives 0 during the ninth bit slot after a device-select byte, after a word-address byte, and after each write-data byte.
- R5: The word address is taken MSB first and masked to the array size. Each write-data bit replaces its bit of the addressed byte as soon as it is sampled, so a byte cut short by a stop keeps the bits already sent.
- R6: After a complete write byte, the address bits selected by the page mask (default 0xFF) advance by one and wrap, while the bits above them stay unchanged. With the default mask, address 0xFF is followed by 0x00.
- R7: In read mode the slave sends each byte MSB first. After the eighth bit, the word address advances by one and wraps over the whole array, so address 0xFF is followed by 0x00.
- R8: If the master leaves the data line high in the acknowledge slot of a read (no acknowledge), the block parks. It then ignores start conditions and clock activity until a stop. If the master pulls the line low, reading continues with the next byte.
- R9: The storage index is the device address joined above the word address and cut to the array's address width. With the default 256-byte array, the device address has no effect.
- R10: When no host write occurs, host_rdata does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Write strobe; one update step per cycle in which it is high |
| host_wdata | input | 2 | Line levels: bit 0 data, bit 1 clock |
| host_rdata | output | 2 | Bit 1 is the slave data level; bit 0 is 0 |

## Verification
A wrong counter or state value appears at the readback within one bit slot. Either an acknowledge goes missing, or it arrives in the wrong slot, or a read bit comes out of the wrong position. A wrong address increment only appears later: the next byte read back differs from the model, and a wrap error only shows at the array or page boundary. For this reason the bench writes the whole array and reads it back in one sequential pass. It also runs a separate pass over the boundary between 0xFF and 0x00, and it tests a byte cut short by a stop.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SEL,
    ST_WADR,
    ST_WDAT,
    ST_RDAT
  } eep_state_e;

  typedef enum logic [1:0] {
    OUT_ECHO,
    OUT_ACK,
    OUT_MEM
  } out_mode_e;
endpackage

// File: rtl/eep_line_tracker.sv
module eep_line_tracker (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic sda_new,
  input  logic scl_new,
  output logic sda_q,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else if (strobe) begin
      sda_q <= sda_new;
      scl_q <= scl_new;
    end
  end

  always_comb begin
    ev_start = strobe & scl_new & sda_q & ~sda_new;
    ev_stop  = strobe & scl_new & ~sda_q & sda_new;
    ev_rise  = strobe & ~scl_q & scl_new;
    ev_fall  = strobe & scl_q & ~scl_new;
  end
endmodule

// File: rtl/eep_bitmem.sv
module eep_bitmem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  localparam int DEPTH = 1 << AW;

  logic store [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wbit;
    rbit <= store[raddr];
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              bit_in,
  output logic              mem_we,
  output logic [MEM_AW+2:0] mem_waddr,
  output logic              mem_wbit,
  output logic [MEM_AW+2:0] mem_raddr,
  output out_mode_e         mode_q,
  output eep_state_e        state_q,
  output logic [3:0]        cnt_q
);
  localparam int DEV_W = 3;
  localparam int WORD_W = 8;
  localparam logic [WORD_W-1:0] WMASK =
    (MEM_AW >= WORD_W) ? {WORD_W{1'b1}} : WORD_W'((1 << MEM_AW) - 1);
  localparam logic [WORD_W-1:0] PMASK = WORD_W'((1 << PAGE_W) - 1);

  eep_state_e        state_n;
  logic [3:0]        cnt_n;
  logic [DEV_W-1:0]  dev_q, dev_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              rw_q, rw_n;
  out_mode_e         mode_n;
  logic [1:0]        dev_idx;
  logic [2:0]        wbit_idx;
  logic [MEM_AW-1:0] wbyte, rbyte;

  assign dev_idx  = 2'(4'd7 - cnt_q);
  assign wbit_idx = 3'(4'd8 - cnt_q);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    dev_n   = dev_q;
    word_n  = word_q;
    rw_n    = rw_q;
    mem_we  = 1'b0;
    if (ev_start && state_q != ST_HOLD) begin
      state_n = ST_SEL;
      cnt_n   = 4'd0;
    end else if (ev_stop) begin
      state_n = ST_IDLE;
    end else begin
      case (state_q)
        ST_SEL: begin
          if (ev_rise && cnt_q == 4'd0) begin
            cnt_n = 4'd1;
          end else if (ev_fall && cnt_q != 4'd0) begin
            if (cnt_q <= 4'd4) begin
              cnt_n = cnt_q + 4'd1;
            end else if (cnt_q <= 4'd7) begin
              dev_n[dev_idx] = bit_in;
              cnt_n = cnt_q + 4'd1;
            end else if (cnt_q == 4'd8) begin
              rw_n  = bit_in;
              cnt_n = 4'd9;
            end else begin
              cnt_n   = 4'd1;
              state_n = rw_q ? ST_RDAT : ST_WADR;
            end
          end
        end
        ST_WADR: begin
          if (ev_fall) begin
            if (cnt_q < 4'd9) begin
              word_n[wbit_idx] = bit_in;
              cnt_n = cnt_q + 4'd1;
            end else begin
              cnt_n   = 4'd1;
              word_n  = word_q & WMASK;
              state_n = ST_WDAT;
            end
          end
        end
        ST_WDAT: begin
          if (ev_fall) begin
            if (cnt_q < 4'd9) begin
              mem_we = 1'b1;
              if (cnt_q == 4'd8)
                word_n = (word_q & ~PMASK) | ((word_q + 8'd1) & PMASK);
              cnt_n = cnt_q + 4'd1;
            end else begin
              cnt_n = 4'd1;
            end
          end
        end
        ST_RDAT: begin
          if (ev_fall) begin
            if (cnt_q < 4'd9) begin
              if (cnt_q == 4'd8) word_n = (word_q + 8'd1) & WMASK;
              cnt_n = cnt_q + 4'd1;
            end else begin
              cnt_n = 4'd1;
              if (bit_in) state_n = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (state_n == ST_RDAT && cnt_n != 4'd0 && cnt_n <= 4'd8)
      mode_n = OUT_MEM;
    else if ((state_n == ST_SEL || state_n == ST_WADR || state_n == ST_WDAT)
             && cnt_n == 4'd9)
      mode_n = OUT_ACK;
    else
      mode_n = OUT_ECHO;
  end

  assign wbyte     = MEM_AW'({dev_q, word_q});
  assign rbyte     = MEM_AW'({dev_n, word_n});
  assign mem_waddr = {wbyte, wbit_idx};
  assign mem_wbit  = bit_in;
  assign mem_raddr = {rbyte, 3'(4'd8 - cnt_n)};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      dev_q   <= '0;
      word_q  <= '0;
      rw_q    <= 1'b0;
      mode_q  <= OUT_ECHO;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      dev_q   <= dev_n;
      word_q  <= word_n;
      rw_q    <= rw_n;
      mode_q  <= mode_n;
    end
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int PAGE_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_we,
  input  logic [1:0] host_wdata,
  output logic [1:0] host_rdata
);
  localparam int BIT_AW = MEM_AW + 3;

  logic              sda_q, ev_start, ev_stop, ev_rise, ev_fall;
  logic              mem_we, mem_wbit, rbit;
  logic [BIT_AW-1:0] mem_waddr, mem_raddr;
  out_mode_e         mode_w;
  eep_state_e        st_w;
  logic [3:0]        cnt_w;
  logic              slave_sda;

  eep_line_tracker u_line (
    .clk(clk), .rst(rst), .strobe(host_we),
    .sda_new(host_wdata[0]), .scl_new(host_wdata[1]),
    .sda_q(sda_q), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  eep_ctrl #(.MEM_AW(MEM_AW), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .bit_in(sda_q),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wbit(mem_wbit),
    .mem_raddr(mem_raddr), .mode_q(mode_w), .state_q(st_w), .cnt_q(cnt_w)
  );

  eep_bitmem #(.AW(BIT_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wbit(mem_wbit),
    .raddr(mem_raddr), .rbit(rbit)
  );

  always_comb begin
    case (mode_w)
      OUT_MEM: slave_sda = rbit;
      OUT_ACK: slave_sda = 1'b0;
      default: slave_sda = sda_q;
    endcase
  end

  assign host_rdata = {slave_sda, 1'b0};
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk
  import eep_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       host_we,
  input logic [1:0] host_wdata,
  input logic [1:0] host_rdata,
  input eep_state_e st,
  input logic [3:0] cnt
);
  logic sh_sda;
  logic stop_now, start_now;

  always_ff @(posedge clk) begin
    if (rst) sh_sda <= 1'b1;
    else if (host_we) sh_sda <= host_wdata[0];
  end

  assign stop_now  = host_we && host_wdata[1] && !sh_sda && host_wdata[0];
  assign start_now = host_we && host_wdata[1] && sh_sda && !host_wdata[0];

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> host_rdata == 2'b10);

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
    stop_now |=> (host_rdata[1] == 1'b1 && st == ST_IDLE));

  assert_start_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (start_now && st != ST_HOLD) |=> (st == ST_SEL && cnt == 4'd0));

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= 4'd9);

  assert_ack_low_R4: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_SEL || st == ST_WADR || st == ST_WDAT) && cnt == 4'd9)
      |-> host_rdata[1] == 1'b0);

  assert_park_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !stop_now) |=> st == ST_HOLD);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !host_we |=> $stable(host_rdata));
endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .st(st_w), .cnt(cnt_w)
);

// File: tb/eep_i2c_slave_bench.sv
module eep_i2c_slave_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [1:0] host_wdata = 2'b11;
  logic [1:0] host_rdata;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;
  logic [7:0] model [0:255];

  always #2 clk = ~clk;

  eep_i2c_slave u_eep_i2c_slave (
    .clk(clk), .rst(rst), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 37 + 11);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic s, input logic c);
    @(negedge clk); host_we = 1'b1; host_wdata = {c, s};
    @(negedge clk); host_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    put(b, 1'b0); put(b, 1'b1); put(b, 1'b0);
  endtask

  task automatic slave_ack(input string tag);
    put(1'b1, 1'b0);
    chk(tag, {7'd0, host_rdata[1]}, 8'd0);
    put(1'b1, 1'b1); put(1'b1, 1'b0);
  endtask

  task automatic send_byte(input logic [7:0] v, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    slave_ack(tag);
  endtask

  task automatic go_start;
    put(1'b1, 1'b0); put(1'b1, 1'b1); put(1'b0, 1'b1); put(1'b0, 1'b0);
  endtask

  task automatic go_stop;
    put(1'b0, 1'b0); put(1'b0, 1'b1); put(1'b1, 1'b1);
  endtask

  task automatic read_byte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      put(1'b1, 1'b0);
      v[i] = host_rdata[1];
      put(1'b1, 1'b1); put(1'b1, 1'b0);
    end
    put(mack, 1'b0); put(mack, 1'b1); put(mack, 1'b0);
  endtask

  // set address then switch to reading (type code 0110 shows it is ignored)
  task automatic open_read(input logic [2:0] dev, input logic [7:0] adr);
    go_start;
    send_byte({4'b1010, dev, 1'b0}, "R4 devsel-w ack");
    send_byte(adr, "R4 word-addr ack");
    go_start;
    send_byte({4'b0110, dev, 1'b1}, "R4 devsel-r ack");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset readback", {6'd0, host_rdata}, 8'h02);

    // R2 echo in idle
    put(1'b0, 1'b0);
    chk("R2 idle echo low", {7'd0, host_rdata[1]}, 8'd0);
    put(1'b1, 1'b0);
    chk("R2 idle echo high", {7'd0, host_rdata[1]}, 8'd1);
    put(1'b1, 1'b1);

    // full sweep write with device 5 (R9: ignored for 256 bytes), R3, R5, R6
    go_start;
    send_byte({4'b1010, 3'd5, 1'b0}, "R4 devsel ack");
    send_byte(8'h00, "R4 word-addr ack");
    for (int k = 0; k < 256; k++) begin
      model[k] = pat(k);
      send_byte(pat(k), "R4 write-data ack");
    end
    go_stop;
    chk("R2 stop echo", {7'd0, host_rdata[1]}, 8'd1);

    // full sweep read with device 0, wrapping past 0xFF (R7, R9)
    open_read(3'd0, 8'h00);
    for (int k = 0; k < 257; k++) begin
      read_byte(v, (k == 256) ? 1'b1 : 1'b0);
      chk($sformatf("R7 R9 read byte %0d", k), v, model[k % 256]);
    end

    // R8 parked: start and clocked bits ignored, no ack
    go_start;
    for (int i = 7; i >= 0; i--) send_bit(i[0]);
    put(1'b1, 1'b0);
    chk("R8 parked no ack", {7'd0, host_rdata[1]}, 8'd1);
    go_stop;
    open_read(3'd2, 8'h10);
    read_byte(v, 1'b1);
    chk("R8 recovery read", v, model[16]);
    go_stop;

    // R6 write wrap 0xFE..0x00
    go_start;
    send_byte({4'b1010, 3'd0, 1'b0}, "R4 devsel ack");
    send_byte(8'hFE, "R4 word-addr ack");
    send_byte(8'h11, "R6 ack"); send_byte(8'h22, "R6 ack"); send_byte(8'h33, "R6 ack");
    go_stop;
    model[254] = 8'h11; model[255] = 8'h22; model[0] = 8'h33;
    open_read(3'd0, 8'hFE);
    for (int k = 0; k < 4; k++) begin
      read_byte(v, (k == 3) ? 1'b1 : 1'b0);
      chk($sformatf("R6 wrap byte %0d", k), v, model[(254 + k) % 256]);
    end
    go_stop;

    // R5 partial byte: high nibble 0x5 then stop
    go_start;
    send_byte({4'b1010, 3'd0, 1'b0}, "R4 devsel ack");
    send_byte(8'h40, "R4 word-addr ack");
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    go_stop;
    model[64] = {4'h5, model[64][3:0]};
    open_read(3'd0, 8'h40);
    // R10: readback holds with no host write while a data bit is presented
    v[0] = host_rdata[1];
    repeat (20) @(negedge clk);
    chk("R10 hold", {6'd0, host_rdata}, {6'd0, v[0], 1'b0});
    read_byte(v, 1'b1);
    chk("R5 partial byte", v, model[64]);
    go_stop;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule